// File: doc/BRIEF.md
# SD Card Native-Bus Bring-Up Sequencer

The sequencer walks an SD or SDHC card from power-up into the transfer state over the one-bit native command line. It does not send commands itself. It hands each step to a separate command engine through a request/acknowledge handshake. Each step is either an idle-clock burst, with the command line held high for a parameterised number of clocks, or a command given as a 6-bit index and a 32-bit argument. The engine answers each step with an acknowledge pulse. In that same cycle it presents the upper 16 bits of the short response and a timeout flag. Long responses are not decoded. The sequencer follows the identification command with an idle burst so that the engine clocks past the long response.

A `start` pulse launches the sequence. The states, in order, are:
- `ST_OFF`: idle, waiting for `start`.
- `ST_WAKE`: wake-up idle burst.
- `ST_GO_IDLE`: CMD0.
- `ST_IF_COND`: CMD8.
- `ST_APP_POLL` and `ST_OP_COND`: CMD55 then ACMD41, repeated while the card reports busy.
- `ST_ALL_CID`: CMD2.
- `ST_SKIP_CID`: idle burst.
- `ST_REL_ADDR`: CMD3, which captures the card address.
- `ST_SELECT`: CMD7.
- `ST_APP_BUS`: CMD55.
- `ST_BUS_WIDTH`: ACMD6.
- `ST_DONE` or `ST_FAIL`: terminal.

Each transition fires on an acknowledge. `ST_OFF` moves to `ST_WAKE` on `start`, and every issuing state moves to the next one listed above. There are three exceptions:
- `ST_OP_COND` returns to `ST_APP_POLL` while the ready bit is 0.
- Any command state except `ST_GO_IDLE` goes to `ST_FAIL` when its acknowledge carries a timeout.
- `ST_BUS_WIDTH` goes to `ST_DONE`.

Top module: `sd_init_seq`

## Requirements
- R1: While reset is held, and after its release, `cmd_req`, `busy`, `done` and `error` are 0 until `start` is seen.
- R2: The first request after `start` is an idle burst: `cmd_idle`=1 and `idle_len`=IDLE_CLKS (256 by default).
- R3: When no step times out, the requests come in this order: idle, CMD0, CMD8, one or more pairs of (CMD55, ACMD41), CMD2, idle, CMD3, CMD7, CMD55, ACMD6. Command requests have `cmd_idle`=0.
- R4: CMD0 and CMD8 carry argument 0x00000122. CMD55 inside the ready poll carries 0x00000000.
- R5: ACMD41 carries 0xC0FF0000. The CMD55/ACMD41 pair repeats until the ACMD41 acknowledge shows `rsp_hi[15]`=1.
- R6: A timeout on the poll-loop CMD55 sends the sequencer to error, and no further request is made.
- R7: A timeout is ignored on CMD0 and on idle bursts. On any other command it ends the sequence in error right after that command.
- R8: An idle burst of IDLE_CLKS clocks follows CMD2 and comes before CMD3.
- R9: The `rsp_hi` value returned with CMD3 is the card address. CMD7 and the final CMD55 carry it in argument bits 31:16, with bits 15:0 zero.
- R10: ACMD6 carries argument 0x00000002, which selects the four-bit bus.
- R11: `cmd_req`, `cmd_idle`, `cmd_idx` and `cmd_arg` hold steady until `cmd_ack`. `cmd_req` is 0 in the cycle after the acknowledge.
- R12: `done` and `error` are never both 1. Once either is 1 it stays 1 until reset, and `start` no longer has any effect.
- R13: `busy` is 1 from the cycle after `start` until `done` or `error` rises, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only in `ST_OFF` |
| cmd_req | output | 1 | Step request to the command engine |
| cmd_idle | output | 1 | 1: the request is an idle-clock burst; 0: it is a command |
| idle_len | output | CNT_W | Number of idle clocks in a burst |
| cmd_idx | output | IDX_W | Command index |
| cmd_arg | output | ARG_W | Command argument |
| cmd_ack | input | 1 | Single-cycle completion pulse from the engine |
| rsp_hi | input | RSP_W | Upper response bits, valid with `cmd_ack` |
| rsp_timeout | input | 1 | Response timeout, valid with `cmd_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Card reached transfer state with the four-bit bus |
| error | output | 1 | A response timed out |

## Verification
The bench plays the command engine. It sweeps the number of busy ACMD41 answers from zero to four against acknowledge latencies of zero to two cycles. This separates the poll-loop count, the handshake timing and the argument of every step, and each run uses a different card address to show that it is captured rather than fixed. A second sweep injects a timeout at every step position in turn. This separates the steps whose timeout must be ignored (the bursts and CMD0) from those that must end the sequence, and checks that the sequence stops exactly after the failing step. After each run, a late `start` pulse checks that the terminal state ignores it.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_WAKE,
        ST_GO_IDLE,
        ST_IF_COND,
        ST_APP_POLL,
        ST_OP_COND,
        ST_ALL_CID,
        ST_SKIP_CID,
        ST_REL_ADDR,
        ST_SELECT,
        ST_APP_BUS,
        ST_BUS_WIDTH,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam logic [5:0] IX_GO_IDLE   = 6'd0;
    localparam logic [5:0] IX_ALL_CID   = 6'd2;
    localparam logic [5:0] IX_REL_ADDR  = 6'd3;
    localparam logic [5:0] IX_BUS_WIDTH = 6'd6;
    localparam logic [5:0] IX_SELECT    = 6'd7;
    localparam logic [5:0] IX_IF_COND   = 6'd8;
    localparam logic [5:0] IX_OP_COND   = 6'd41;
    localparam logic [5:0] IX_APP       = 6'd55;

endpackage

// File: rtl/sd_init_fsm.sv
module sd_init_fsm
    import sd_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmd_ack,
    input  logic       rsp_timeout,
    input  logic       rsp_ready,
    output seq_state_t state,
    output logic       gap
);

    seq_state_t state_nx;
    logic       adv;

    assign adv = cmd_ack && !gap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            gap   <= 1'b0;
        end else begin
            state <= state_nx;
            gap   <= adv;
        end
    end

    // transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:       if (start) state_nx = ST_WAKE;
            ST_WAKE:      if (adv) state_nx = ST_GO_IDLE;
            ST_GO_IDLE:   if (adv) state_nx = ST_IF_COND;
            ST_IF_COND:   if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_APP_POLL;
            ST_APP_POLL:  if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_OP_COND;
            ST_OP_COND: begin
                if (adv) begin
                    if (rsp_timeout)    state_nx = ST_FAIL;
                    else if (rsp_ready) state_nx = ST_ALL_CID;
                    else                state_nx = ST_APP_POLL;
                end
            end
            ST_ALL_CID:   if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_SKIP_CID;
            ST_SKIP_CID:  if (adv) state_nx = ST_REL_ADDR;
            ST_REL_ADDR:  if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_SELECT;
            ST_SELECT:    if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_APP_BUS;
            ST_APP_BUS:   if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_BUS_WIDTH;
            ST_BUS_WIDTH: if (adv) state_nx = rsp_timeout ? ST_FAIL : ST_DONE;
            ST_DONE:      state_nx = ST_DONE;
            ST_FAIL:      state_nx = ST_FAIL;
            default:      state_nx = ST_OFF;
        endcase
    end

endmodule

// File: rtl/sd_init_rca.sv
module sd_init_rca
    import sd_init_pkg::*;
#(
    parameter int RSP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state,
    input  logic             cmd_ack,
    input  logic             gap,
    input  logic             rsp_timeout,
    input  logic [RSP_W-1:0] rsp_hi,
    output logic [RSP_W-1:0] rca
);

    logic take;

    assign take = (state == ST_REL_ADDR) && cmd_ack && !gap && !rsp_timeout;

    always_ff @(posedge clk) begin
        if (!rst_n)    rca <= '0;
        else if (take) rca <= rsp_hi;
    end

endmodule

// File: rtl/sd_init_cmdmux.sv
module sd_init_cmdmux
    import sd_init_pkg::*;
#(
    parameter int               IDX_W   = 6,
    parameter int               ARG_W   = 32,
    parameter int               RSP_W   = 16,
    parameter logic [ARG_W-1:0] ARG_IFC = 32'h0000_0122,
    parameter logic [ARG_W-1:0] ARG_OPC = 32'hC0FF_0000,
    parameter logic [ARG_W-1:0] ARG_BUS = 32'h0000_0002
) (
    input  seq_state_t       state,
    input  logic [RSP_W-1:0] rca,
    output logic             issue,
    output logic             idle,
    output logic [IDX_W-1:0] idx,
    output logic [ARG_W-1:0] arg
);

    localparam int LOW_W = ARG_W - RSP_W;

    logic [ARG_W-1:0] rca_arg;
    assign rca_arg = {rca, {LOW_W{1'b0}}};

    always_comb begin
        issue = 1'b1;
        idle  = 1'b0;
        idx   = '0;
        arg   = '0;
        unique case (state)
            ST_WAKE, ST_SKIP_CID: idle = 1'b1;
            ST_GO_IDLE:   begin idx = IDX_W'(IX_GO_IDLE);   arg = ARG_IFC; end
            ST_IF_COND:   begin idx = IDX_W'(IX_IF_COND);   arg = ARG_IFC; end
            ST_APP_POLL:  begin idx = IDX_W'(IX_APP);       arg = '0;      end
            ST_OP_COND:   begin idx = IDX_W'(IX_OP_COND);   arg = ARG_OPC; end
            ST_ALL_CID:   begin idx = IDX_W'(IX_ALL_CID);   arg = '0;      end
            ST_REL_ADDR:  begin idx = IDX_W'(IX_REL_ADDR);  arg = '0;      end
            ST_SELECT:    begin idx = IDX_W'(IX_SELECT);    arg = rca_arg; end
            ST_APP_BUS:   begin idx = IDX_W'(IX_APP);       arg = rca_arg; end
            ST_BUS_WIDTH: begin idx = IDX_W'(IX_BUS_WIDTH); arg = ARG_BUS; end
            ST_OFF, ST_DONE, ST_FAIL: issue = 1'b0;
            default: issue = 1'b0;
        endcase
    end

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int               IDLE_CLKS = 256,
    parameter int               IDX_W     = 6,
    parameter int               ARG_W     = 32,
    parameter int               RSP_W     = 16,
    parameter logic [ARG_W-1:0] ARG_IFC   = 32'h0000_0122,
    parameter logic [ARG_W-1:0] ARG_OPC   = 32'hC0FF_0000,
    parameter logic [ARG_W-1:0] ARG_BUS   = 32'h0000_0002,
    localparam int              CNT_W     = $clog2(IDLE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             cmd_req,
    output logic             cmd_idle,
    output logic [CNT_W-1:0] idle_len,
    output logic [IDX_W-1:0] cmd_idx,
    output logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_ack,
    input  logic [RSP_W-1:0] rsp_hi,
    input  logic             rsp_timeout,
    output logic             busy,
    output logic             done,
    output logic             error
);

    localparam int READY_BIT = RSP_W - 1;

    seq_state_t       state;
    logic             gap;
    logic             issue;
    logic [RSP_W-1:0] rca;

    sd_init_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd_ack     (cmd_ack),
        .rsp_timeout (rsp_timeout),
        .rsp_ready   (rsp_hi[READY_BIT]),
        .state       (state),
        .gap         (gap)
    );

    sd_init_rca #(.RSP_W(RSP_W)) u_rca (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .cmd_ack     (cmd_ack),
        .gap         (gap),
        .rsp_timeout (rsp_timeout),
        .rsp_hi      (rsp_hi),
        .rca         (rca)
    );

    sd_init_cmdmux #(
        .IDX_W   (IDX_W),
        .ARG_W   (ARG_W),
        .RSP_W   (RSP_W),
        .ARG_IFC (ARG_IFC),
        .ARG_OPC (ARG_OPC),
        .ARG_BUS (ARG_BUS)
    ) u_mux (
        .state (state),
        .rca   (rca),
        .issue (issue),
        .idle  (cmd_idle),
        .idx   (cmd_idx),
        .arg   (cmd_arg)
    );

    assign idle_len = CNT_W'(IDLE_CLKS);

    // output decode
    always_comb begin
        cmd_req = issue && !gap;
        done    = (state == ST_DONE);
        error   = (state == ST_FAIL);
        busy    = (state != ST_OFF) && (state != ST_DONE) && (state != ST_FAIL);
    end

endmodule

// File: rtl/sd_init_seq_chk.sv
module sd_init_seq_chk #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_req,
    input logic             cmd_idle,
    input logic [IDX_W-1:0] cmd_idx,
    input logic [ARG_W-1:0] cmd_arg,
    input logic             cmd_ack,
    input logic             busy,
    input logic             done,
    input logic             error
);

    p_wake_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd_req && cmd_idle);

    p_quiet_after_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !cmd_req);

    p_rca_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_idle && cmd_idx == IDX_W'(7)) |-> cmd_arg[15:0] == 16'h0);

    p_bus_arg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_idle && cmd_idx == IDX_W'(6)) |-> cmd_arg == ARG_W'(2));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> cmd_req && $stable(cmd_idx) && $stable(cmd_arg) && $stable(cmd_idle));

    p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ack) |=> !cmd_req);

    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_error_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    p_req_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> busy && !done && !error);

endmodule

bind sd_init_seq sd_init_seq_chk #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_req  (cmd_req),
    .cmd_idle (cmd_idle),
    .cmd_idx  (cmd_idx),
    .cmd_arg  (cmd_arg),
    .cmd_ack  (cmd_ack),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/sd_init_seq_tb.sv
`timescale 1ns/1ps
module sd_init_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_req, cmd_idle;
    logic [8:0]  idle_len;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic        cmd_ack = 1'b0;
    logic [15:0] rsp_hi = '0;
    logic        rsp_timeout = 1'b0;
    logic        busy, done, error;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sd_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_req(cmd_req), .cmd_idle(cmd_idle), .idle_len(idle_len),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_ack(cmd_ack),
        .rsp_hi(rsp_hi), .rsp_timeout(rsp_timeout),
        .busy(busy), .done(done), .error(error)
    );

    // expected step list
    logic        e_idle [32];
    logic [5:0]  e_idx  [32];
    logic [31:0] e_arg  [32];
    logic [15:0] e_rsp  [32];
    logic        e_kill [32];
    string       e_tag  [32];
    int          e_len;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic idl, input logic [5:0] ix, input logic [31:0] ar,
                       input logic [15:0] rs, input logic kl, input string tg);
        e_idle[e_len] = idl; e_idx[e_len] = ix; e_arg[e_len] = ar;
        e_rsp[e_len] = rs; e_kill[e_len] = kl; e_tag[e_len] = tg;
        e_len++;
    endtask

    task automatic build(input int polls, input logic [15:0] rca);
        e_len = 0;
        put(1, 0, 0, 16'h1234, 0, "R2");
        put(0, 0, 32'h122, 16'h1234, 0, "R4");
        put(0, 8, 32'h122, 16'h0122, 1, "R4");
        for (int i = 0; i <= polls; i++) begin
            put(0, 55, 32'h0, 16'h0120, 1, "R4");
            put(0, 41, 32'hC0FF0000, (i == polls) ? 16'hC0FF : 16'h40FF, 1, "R5");
        end
        put(0, 2, 0, 16'h1234, 1, "R3");
        put(1, 0, 0, 16'h1234, 0, "R8");
        put(0, 3, 0, rca, 1, "R3");
        put(0, 7, {rca, 16'h0}, 16'h0700, 1, "R9");
        put(0, 55, {rca, 16'h0}, 16'h0920, 1, "R9");
        put(0, 6, 32'h2, 16'h0920, 1, "R10");
    endtask

    task automatic run_case(input int polls, input int lat, input logic [15:0] rca, input int fail_at);
        int  step = 0;
        bit  term = 0;
        bit  expect_err;
        int  exp_steps;
        build(polls, rca);
        expect_err = (fail_at >= 0) && (fail_at < e_len) && e_kill[fail_at];
        exp_steps  = expect_err ? fail_at + 1 : e_len;
        rst_n = 0; cmd_ack = 0; start = 0; rsp_timeout = 0;
        repeat (3) @(negedge clk);
        chk(!cmd_req && !busy && !done && !error, "R1 in reset", {busy, done, error, cmd_req}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!cmd_req && !busy && !done && !error, "R1 after reset", {busy, done, error, cmd_req}, 0);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy, "R13 busy after start", busy, 1);
        while (!term) begin
            int wait_n = 0;
            while (!cmd_req && !done && !error && wait_n < 200) begin
                @(negedge clk);
                wait_n++;
            end
            if (cmd_req) begin
                if (step >= e_len) begin
                    chk(0, "R3 extra request", step, e_len);
                    term = 1;
                end else begin
                    chk(cmd_idle == e_idle[step] && (e_idle[step] || (cmd_idx == e_idx[step] && cmd_arg == e_arg[step])),
                        e_tag[step], {cmd_idle, 1'b0, cmd_idx, cmd_arg}, {e_idle[step], 1'b0, e_idx[step], e_arg[step]});
                    if (cmd_idle) chk(idle_len == 9'd256, e_tag[step], idle_len, 256);
                    chk(busy && !done && !error, "R13 busy during step", {busy, done, error}, 3'b100);
                    for (int k = 0; k < lat; k++) begin
                        @(negedge clk);
                        chk(cmd_req && cmd_idle == e_idle[step] && (e_idle[step] || cmd_arg == e_arg[step]),
                            "R11 hold", {cmd_req, cmd_arg}, {1'b1, e_arg[step]});
                    end
                    rsp_hi = e_rsp[step];
                    rsp_timeout = (step == fail_at);
                    cmd_ack = 1;
                    @(negedge clk);
                    cmd_ack = 0; rsp_timeout = 0; rsp_hi = '0;
                    chk(!cmd_req, "R11 drop", cmd_req, 0);
                    step++;
                end
            end else if (done || error) begin
                term = 1;
            end else begin
                chk(0, "R3 stalled", step, exp_steps);
                term = 1;
            end
        end
        chk(step == exp_steps, expect_err ? (e_tag[fail_at] == "R4" && e_idx[fail_at] == 55 ? "R6 steps" : "R7 steps") : "R3 steps",
            step, exp_steps);
        chk(error == expect_err && done == !expect_err && !busy,
            expect_err ? "R6 R7 error end" : "R7 done end", {busy, done, error}, {1'b0, !expect_err, expect_err});
        start = 1;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 5; k++) begin
            chk(!cmd_req && error == expect_err && done == !expect_err && !busy,
                "R12 terminal", {cmd_req, busy, done, error}, {2'b00, !expect_err, expect_err});
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int p = 0; p <= 4; p++)
            for (int l = 0; l <= 2; l++)
                run_case(p, l, 16'hA5C3 ^ 16'(p * 16'h1111 + l * 16'h0101), -1);
        for (int f = 0; f < 13; f++)
            run_case(1, f % 3, 16'h3C5A + 16'(f), f);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule